// File: doc/BRIEF.md
# Flash Write-Status Polling Generator

This block produces the status a flash device shows on its read bus while an embedded program or erase runs in the array. An operation is accepted with a start pulse that carries its kind, the target address, the data byte being programmed and a flag stating that the targeted sectors are write-protected. The array engine reports completion with a done pulse. Meanwhile the host may read any address. The block returns the bit-7 polling value for that address. It also drives a ready flag that goes low while an operation is in flight.

The polling bit depends on the operation. A program shows the inverse of data bit 7 until it completes, and the true bit afterwards. An erase shows 0 while busy and 1 when done. A status read is only meaningful at a qualifying address: the exact program address, a location in the sector being erased, or any address for a chip erase. When the target is protected, the array engine never starts. The block then fakes a short busy window, counted in clock cycles from a clock-frequency parameter, and returns to plain read mode with no result. The window is about 1 us for a program and about 100 us for an erase.

Top module: `flash_poll_status`

## Requirements
- R1: After reset `ready_o` is 1, `poll_o` is 0 and `dq7_o` is 1 at every read address.
- R2: A start with `op_i` = 2'b00 (program), accepted while `ready_o` is 1, drives `ready_o` to 0 and `poll_o` to 1 from the next cycle. While busy, `dq7_o` is the inverse of `data_i[7]` when `rd_addr_i` equals the program address.
- R3: A `done_i` pulse during an unprotected operation returns `ready_o` to 1 and `poll_o` to 0 in the next cycle. After a program, `dq7_o` then shows the true programmed bit 7 at the program address until the next accepted start.
- R4: A sector erase (`op_i` = 2'b01) reads 0 on `dq7_o` while busy, and 1 after done, for any `rd_addr_i` whose bits above `SECT_LSB` match the target address.
- R5: A chip erase (`op_i` = 2'b10) qualifies every read address: `dq7_o` is 0 while busy and 1 after done.
- R6: While busy, a read address that does not qualify returns 1 on `dq7_o`.
- R7: A protected program keeps `ready_o` low for exactly `CLK_FREQ_MHZ*PROG_WIN_NS/1000` cycles, showing the inverse bit 7 at the address. It then returns to read mode, with `dq7_o` = 1 and no result held.
- R8: A protected erase of either kind keeps `ready_o` low for exactly `CLK_FREQ_MHZ*ERASE_WIN_NS/1000` cycles, showing 0 at qualifying addresses. It then returns to read mode.
- R9: A start pulse while `ready_o` is 0 is ignored. The running operation, its address and its data are unchanged.
- R10: `done_i` has no effect while ready, or during a protected window. The window length is unchanged.
- R11: A start with the reserved code `op_i` = 2'b11 is ignored. `ready_o` stays 1 and any held result is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Operation start pulse (final write strobe of the command) |
| op_i | input | 2 | Operation kind: 00 program, 01 sector erase, 10 chip erase, 11 reserved |
| addr_i | input | ADDR_W | Target address of the operation |
| data_i | input | 8 | Byte being programmed |
| prot_i | input | 1 | Targeted sectors are all protected |
| done_i | input | 1 | Completion pulse from the array engine |
| rd_addr_i | input | ADDR_W | Current read address |
| dq7_o | output | 1 | Polling bit for read-data bit 7 |
| poll_o | output | 1 | Status mode: the read bus should carry polling data |
| ready_o | output | 1 | 1 ready, 0 busy |

## Verification
The assertions assume that the array engine raises `done_i` only while its own operation runs. A `done_i` that arrives during a protected window is tolerated, but it carries no meaning. They also assume that the read address is steady across each sampled cycle, and that the timing parameters give windows of at least one cycle. The stimulus raises `done_i` only after a busy period of random length. It also sends stray done pulses into idle and protected periods to test that they are ignored. Starts issued during busy periods carry different kinds, addresses and data, so any wrongly accepted start would show up on the polling bit.

// File: rtl/flash_poll_pkg.sv
package flash_poll_pkg;
  typedef enum logic [1:0] {
    OP_PROG  = 2'b00,
    OP_SERA  = 2'b01,
    OP_CERA  = 2'b10,
    OP_RSVD  = 2'b11
  } poll_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_RUN  = 2'b01,
    ST_LOCK = 2'b10,
    ST_HOLD = 2'b11
  } poll_st_e;

  function automatic logic op_ok(input logic [1:0] op);
    return op != OP_RSVD;
  endfunction
endpackage

// File: rtl/flash_poll_timer.sv
module flash_poll_timer #(
  parameter int unsigned PROG_CYC  = 200,
  parameter int unsigned ERASE_CYC = 20000,
  localparam int unsigned CNT_W    = $clog2(ERASE_CYC + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic erase_i,
  input  logic run_i,
  output logic expired_o
);
  localparam logic [CNT_W-1:0] PROG_LD  = CNT_W'(PROG_CYC - 1);
  localparam logic [CNT_W-1:0] ERASE_LD = CNT_W'(ERASE_CYC - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= erase_i ? ERASE_LD : PROG_LD;
    end else if (run_i && cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired_o = run_i && (cnt_q == '0);
endmodule

// File: rtl/flash_poll_match.sv
module flash_poll_match
  import flash_poll_pkg::*;
#(
  parameter int unsigned ADDR_W   = 20,
  parameter int unsigned SECT_LSB = 15
) (
  input  poll_op_e          op_i,
  input  logic [ADDR_W-1:0] tgt_i,
  input  logic [ADDR_W-1:0] rd_i,
  output logic              qual_o
);
  logic same_sect;

  generate
    if (SECT_LSB >= ADDR_W) begin : g_one_sect
      assign same_sect = 1'b1;
    end else begin : g_sects
      assign same_sect = rd_i[ADDR_W-1:SECT_LSB] == tgt_i[ADDR_W-1:SECT_LSB];
    end
  endgenerate

  always_comb begin
    unique case (op_i)
      OP_PROG: qual_o = (rd_i == tgt_i);
      OP_SERA: qual_o = same_sect;
      default: qual_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/flash_poll_ctrl.sv
module flash_poll_ctrl
  import flash_poll_pkg::*;
#(
  parameter int unsigned ADDR_W = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [1:0]        op_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              d7_i,
  input  logic              prot_i,
  input  logic              done_i,
  input  logic              expired_i,
  output logic              load_o,
  output logic              load_erase_o,
  output poll_st_e          st_o,
  output poll_op_e          op_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              d7_o,
  output logic              ready_o
);
  poll_st_e          st_q;
  poll_op_e          op_q;
  logic [ADDR_W-1:0] addr_q;
  logic              d7_q;
  logic              ready_q;
  logic              accept;

  assign accept       = start_i && op_ok(op_i) && (st_q == ST_IDLE || st_q == ST_HOLD);
  assign load_o       = accept && prot_i;
  assign load_erase_o = (op_i != OP_PROG);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      op_q    <= OP_PROG;
      addr_q  <= '0;
      d7_q    <= 1'b0;
      ready_q <= 1'b1;
    end else begin
      unique case (st_q)
        ST_IDLE, ST_HOLD: begin
          if (accept) begin
            st_q    <= prot_i ? ST_LOCK : ST_RUN;
            op_q    <= poll_op_e'(op_i);
            addr_q  <= addr_i;
            d7_q    <= d7_i;
            ready_q <= 1'b0;
          end
        end
        ST_RUN: begin
          if (done_i) begin
            st_q    <= ST_HOLD;
            ready_q <= 1'b1;
          end
        end
        default: begin
          // protected window: no array activity, no result kept
          if (expired_i) begin
            st_q    <= ST_IDLE;
            ready_q <= 1'b1;
          end
        end
      endcase
    end
  end

  assign st_o    = st_q;
  assign op_o    = op_q;
  assign addr_o  = addr_q;
  assign d7_o    = d7_q;
  assign ready_o = ready_q;
endmodule

// File: rtl/flash_poll_status.sv
module flash_poll_status
  import flash_poll_pkg::*;
#(
  parameter int unsigned ADDR_W       = 20,
  parameter int unsigned SECT_LSB     = 15,
  parameter int unsigned CLK_FREQ_MHZ = 200,
  parameter int unsigned PROG_WIN_NS  = 1000,
  parameter int unsigned ERASE_WIN_NS = 100000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [1:0]        op_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        data_i,
  input  logic              prot_i,
  input  logic              done_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic              dq7_o,
  output logic              poll_o,
  output logic              ready_o
);
  localparam int unsigned PROG_RAW  = CLK_FREQ_MHZ * PROG_WIN_NS / 1000;
  localparam int unsigned ERASE_RAW = CLK_FREQ_MHZ * ERASE_WIN_NS / 1000;
  localparam int unsigned PROG_CYC  = (PROG_RAW  == 0) ? 1 : PROG_RAW;
  localparam int unsigned ERASE_CYC = (ERASE_RAW == 0) ? 1 : ERASE_RAW;

  poll_st_e          st;
  poll_op_e          op_q;
  logic [ADDR_W-1:0] addr_q;
  logic              d7_q;
  logic              load, load_erase, expired, qual;

  flash_poll_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .op_i        (op_i),
    .addr_i      (addr_i),
    .d7_i        (data_i[7]),
    .prot_i      (prot_i),
    .done_i      (done_i),
    .expired_i   (expired),
    .load_o      (load),
    .load_erase_o(load_erase),
    .st_o        (st),
    .op_o        (op_q),
    .addr_o      (addr_q),
    .d7_o        (d7_q),
    .ready_o     (ready_o)
  );

  flash_poll_timer #(.PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (load),
    .erase_i  (load_erase),
    .run_i    (st == ST_LOCK),
    .expired_o(expired)
  );

  flash_poll_match #(.ADDR_W(ADDR_W), .SECT_LSB(SECT_LSB)) u_match (
    .op_i  (op_q),
    .tgt_i (addr_q),
    .rd_i  (rd_addr_i),
    .qual_o(qual)
  );

  always_comb begin
    unique case (st)
      ST_RUN, ST_LOCK: dq7_o = qual ? ((op_q == OP_PROG) ? ~d7_q : 1'b0) : 1'b1;
      ST_HOLD:         dq7_o = (qual && op_q == OP_PROG) ? d7_q : 1'b1;
      default:         dq7_o = 1'b1;
    endcase
  end

  assign poll_o = (st == ST_RUN) || (st == ST_LOCK);
endmodule

// File: rtl/flash_poll_status_chk.sv
module flash_poll_status_chk #(
  parameter int unsigned ADDR_W    = 20,
  parameter int unsigned PROG_CYC  = 200,
  parameter int unsigned ERASE_CYC = 20000
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic [1:0]        op_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [7:0]        data_i,
  input logic              prot_i,
  input logic              done_i,
  input logic [ADDR_W-1:0] rd_addr_i,
  input logic              dq7_o,
  input logic              poll_o,
  input logic              ready_o
);
  logic [1:0]        sh_op;
  logic [ADDR_W-1:0] sh_addr;
  logic              sh_d7, sh_prot;
  int unsigned       busy_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_op    <= 2'b00;
      sh_addr  <= '0;
      sh_d7    <= 1'b0;
      sh_prot  <= 1'b0;
      busy_cnt <= 0;
    end else begin
      if (ready_o && start_i && op_i != 2'b11) begin
        sh_op   <= op_i;
        sh_addr <= addr_i;
        sh_d7   <= data_i[7];
        sh_prot <= prot_i;
      end
      busy_cnt <= ready_o ? 0 : busy_cnt + 1;
    end
  end

  a_r2_busy_on_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o && start_i && op_i != 2'b11 |=> !ready_o && poll_o);
  a_r2_prog_dq7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_o && sh_op == 2'b00 && rd_addr_i == sh_addr |-> dq7_o == !sh_d7);
  a_r3_done_ends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_o && !sh_prot && done_i |=> ready_o && !poll_o);
  a_r5_chip_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_o && sh_op == 2'b10 |-> !dq7_o);
  a_r6_unqual_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_o && sh_op == 2'b00 && rd_addr_i != sh_addr |-> dq7_o);
  a_r7_window_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_o && sh_prot |-> busy_cnt < ((sh_op == 2'b00) ? PROG_CYC : ERASE_CYC));
  a_r9_start_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_o && !sh_prot && start_i && !done_i |=> !ready_o);
  a_r10_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o && done_i && !start_i |=> ready_o);
  a_r11_rsvd_op: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o && start_i && op_i == 2'b11 |=> ready_o);
endmodule

bind flash_poll_status flash_poll_status_chk #(
  .ADDR_W(ADDR_W), .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .op_i(op_i),
  .addr_i(addr_i), .data_i(data_i), .prot_i(prot_i), .done_i(done_i),
  .rd_addr_i(rd_addr_i), .dq7_o(dq7_o), .poll_o(poll_o), .ready_o(ready_o)
);

// File: tb/flash_poll_status_tb.sv
`timescale 1ns/1ps
module flash_poll_status_tb;
  localparam int PROG_W  = 200;
  localparam int ERASE_W = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  op = 2'b00;
  logic [19:0] addr = '0;
  logic [7:0]  data = '0;
  logic        prot = 1'b0;
  logic        done = 1'b0;
  logic [19:0] rd_addr = '0;
  logic        dq7, poll, ready;

  always #2.5 clk = ~clk;

  flash_poll_status u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_i(op), .addr_i(addr),
    .data_i(data), .prot_i(prot), .done_i(done), .rd_addr_i(rd_addr),
    .dq7_o(dq7), .poll_o(poll), .ready_o(ready)
  );

  int checks = 0, errors = 0;
  bit finished = 0;

  // bench model
  bit m_busy = 0, m_hold = 0;
  logic [1:0]  m_op = 0;
  logic [19:0] m_addr = 0;
  logic        m_d7 = 0;

  task automatic chk(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  function automatic logic qual(logic [19:0] rd);
    case (m_op)
      2'b00:   return rd == m_addr;
      2'b01:   return rd[19:15] == m_addr[19:15];
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic exp_dq7(logic [19:0] rd);
    if (m_busy) return qual(rd) ? ((m_op == 2'b00) ? ~m_d7 : 1'b0) : 1'b1;
    if (m_hold) return (qual(rd) && m_op == 2'b00) ? m_d7 : 1'b1;
    return 1'b1;
  endfunction

  function automatic logic [19:0] pick_rd();
    case ($urandom % 3)
      0:       return m_addr;
      1:       return {m_addr[19:15], 15'($urandom)};
      default: return 20'($urandom);
    endcase
  endfunction

  task automatic probe(string tag, logic [19:0] rd);
    rd_addr = rd;
    #1;
    chk(tag, dq7, exp_dq7(rd));
  endtask

  task automatic start_op(logic [1:0] o, logic [19:0] a, logic [7:0] d, logic p);
    @(negedge clk);
    start = 1'b1; op = o; addr = a; data = d; prot = p;
    @(negedge clk);
    start = 1'b0;
    if (!m_busy && o != 2'b11) begin
      m_busy = 1; m_hold = 0; m_op = o; m_addr = a; m_d7 = d[7];
    end
  endtask

  task automatic finish_op();
    @(negedge clk); done = 1'b1;
    @(negedge clk); done = 1'b0;
    m_busy = 0; m_hold = 1;
  endtask

  task automatic prot_window(string tag, int win);
    int n = 0;
    while (ready === 1'b0 && n < ERASE_W + 10) begin
      if (n == 0) probe({tag, " dq7 in window"}, m_addr);
      if (n == 3) done = 1'b1;        // R10 stray done
      else        done = 1'b0;
      n++;
      @(negedge clk);
    end
    done = 1'b0;
    checks++;
    if (n != win) begin
      errors++;
      $display("FAIL %s window actual=%0d expected=%0d", tag, n, win);
    end
    m_busy = 0; m_hold = 0;
    chk({tag, " poll after window"}, poll, 1'b0);
    probe({tag, " no result after window"}, m_addr);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    if (!finished) $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 ready", ready, 1'b1);
    chk("R1 poll", poll, 1'b0);
    probe("R1 dq7", 20'h12345);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 done while idle
    @(negedge clk); done = 1'b1; @(negedge clk); done = 1'b0;
    chk("R10 done idle ready", ready, 1'b1);
    chk("R10 done idle poll", poll, 1'b0);

    // R2/R3 directed program, bit7 = 1
    start_op(2'b00, 20'h0ABCD, 8'h80, 1'b0);
    chk("R2 ready low", ready, 1'b0);
    chk("R2 poll high", poll, 1'b1);
    probe("R2 dq7 inverse", 20'h0ABCD);
    probe("R6 neighbour addr", 20'h0ABCC);
    // R9 start while busy
    start_op(2'b10, 20'h55555, 8'h00, 1'b0);
    chk("R9 still busy", ready, 1'b0);
    probe("R9 program addr kept", 20'h0ABCD);
    probe("R9 other addr unqualified", 20'h55555);
    finish_op();
    chk("R3 ready high", ready, 1'b1);
    chk("R3 poll low", poll, 1'b0);
    probe("R3 true bit", 20'h0ABCD);

    // R11 reserved op keeps held result
    start_op(2'b11, 20'h00000, 8'h00, 1'b0);
    chk("R11 ready", ready, 1'b1);
    probe("R11 result kept", 20'h0ABCD);

    // R4 sector erase
    start_op(2'b01, 20'h38000, 8'h00, 1'b0);
    probe("R4 same sector busy", 20'h3FFFF);
    probe("R6 other sector busy", 20'h40000);
    finish_op();
    probe("R4 same sector done", 20'h38001);

    // R5 chip erase
    start_op(2'b10, 20'h00000, 8'h00, 1'b0);
    probe("R5 any addr busy", 20'hFFFFF);
    finish_op();
    probe("R5 any addr done", 20'h12345);

    // R7 protected program, bit7 = 0
    start_op(2'b00, 20'h01234, 8'h11, 1'b1);
    chk("R7 busy", ready, 1'b0);
    prot_window("R7", PROG_W);

    // R8 protected sector erase and chip erase
    start_op(2'b01, 20'h70000, 8'h00, 1'b1);
    prot_window("R8 sector", ERASE_W);
    start_op(2'b10, 20'h00000, 8'h00, 1'b1);
    prot_window("R8 chip", ERASE_W);

    // random unprotected operations
    for (int i = 0; i < 60; i++) begin
      logic [1:0] o = 2'($urandom % 3);
      start_op(o, 20'($urandom), 8'($urandom), 1'b0);
      chk("R2 random busy", ready, 1'b0);
      for (int k = 0; k < 1 + int'($urandom % 8); k++) begin
        if ($urandom % 4 == 0) begin
          start_op(2'($urandom), 20'($urandom), 8'($urandom), 1'b0);
          chk("R9 random busy", ready, 1'b0);
        end
        probe((m_op == 2'b00) ? "R2 random dq7" :
              (m_op == 2'b01) ? "R4 random dq7" : "R5 random dq7", pick_rd());
        @(negedge clk);
      end
      finish_op();
      chk("R3 random ready", ready, 1'b1);
      probe("R3 random held", pick_rd());
      probe("R3 random target", m_addr);
    end

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule